// File: doc/BRIEF.md
# Graphics Memory Aperture Decoder

This block sits between the host memory bus of a PC graphics adapter and its memory-side targets. For every host access it decides whether the address falls in the legacy VGA window, in a 1 KB register window, or in the linear framebuffer aperture. It then raises one target select together with a translated byte offset into video memory or into the register file. An access that hits nothing raises a drop flag. If that access is a read, it returns all-ones on the data bus.

A small configuration port holds the state that steers the decode:
- a PCI-style command byte whose memory-enable bit gates every window;
- the top byte of a 16 MB-aligned aperture base;
- a two-bit aperture size select;
- a four-bit legacy map mode.

The register window always takes the last 1 KB of the aperture, so the framebuffer part is exactly 1 KB shorter than the aperture. The decode path is purely combinational. It accepts an access every cycle and applies no back-pressure, so the host side needs no ready signal. Configuration changes take effect at the clock edge that captures the write.

Top module: `gfx_aperture_decoder`

## Requirements
- R1: After reset, every configuration field reads zero. Configuration addresses are: 0x04 command, 0x12 base low, 0x13 base high, 0x40 aperture size (bits 1:0), 0x41 map mode (bits 3:0). Unlisted addresses read zero.
- R2: A write to the command register keeps only the bits set in mask 0x27, and the value reads back masked.
- R3: While command bit 1 (memory enable) is clear, no target is selected for any address.
- R4: The aperture base is the byte at 0x13 shifted left by 24. A base byte of zero disables the aperture. The byte at 0x12 always reads zero, and writes to it change nothing.
- R5: With aperture size value 2, framebuffer hits cover base to base+0x7FFBFF, and register hits cover base+0x7FFC00 to base+0x7FFFFF. The register offset is the low 10 address bits.
- R6: With any other aperture size value, framebuffer hits cover base to base+0x3FFBFF, and register hits cover base+0x3FFC00 to base+0x3FFFFF.
- R7: In map mode 0, addresses 0xA0000 to 0xBFBFF select VGA with offset addr & 0xFFFF. Addresses 0xBFC00 to 0xBFFFF select the register window with offset addr & 0x3FF.
- R8: In map mode 0xC, addresses 0xB8000 to 0xBFBFF select VGA with offset addr & 0x7FFF, and no legacy register window exists. Every other map mode decodes no legacy window.
- R9: A framebuffer offset (23 bits) at or above the installed VRAM byte count selects nothing. A write there raises the drop flag. A read there also returns all-ones.
- R10: At most one select is high in any cycle. A read hitting VGA or the framebuffer returns VRAM data, and a read hitting the register window returns register data. A read hitting nothing returns all-ones and raises the drop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| vram_bytes | input | 24 | Installed VRAM size in bytes |
| host_addr | input | 32 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| vram_rdata | input | 32 | Read data returned by VRAM |
| reg_rdata | input | 32 | Read data returned by the register file |
| sel_vga | output | 1 | Legacy VGA window hit |
| sel_fb | output | 1 | Linear framebuffer hit |
| sel_reg | output | 1 | Register window hit |
| vram_off | output | 23 | VRAM byte offset for VGA or framebuffer hits |
| reg_off | output | 10 | Register window byte offset |
| host_rdata | output | 32 | Read data to the host |
| host_drop | output | 1 | Access hit no target |

## Verification
A configuration write and a host access can fall in the same cycle.

The bench provokes this by moving the aperture base while a read targets the old base. During that cycle the read must still hit the framebuffer under the old base. One cycle later the same address must miss, with all-ones data.

Around that, the bench sweeps every aperture size against several bases and VRAM sizes at each window boundary, and every map mode against the legacy boundaries. It compares each result with a model computed arithmetically from the requirements.

// File: rtl/gfx_aperture_pkg.sv
package gfx_aperture_pkg;
  localparam int HOST_AW    = 32;
  localparam int BASE_SHIFT = 24;
  localparam int APER_AW    = 23;
  localparam int REG_AW     = 10;
  localparam int REG_WIN    = 1 << REG_AW;

  localparam logic [7:0] CFG_CMD     = 8'h04;
  localparam logic [7:0] CFG_BASE_LO = 8'h12;
  localparam logic [7:0] CFG_BASE_HI = 8'h13;
  localparam logic [7:0] CFG_APSZ    = 8'h40;
  localparam logic [7:0] CFG_MAP     = 8'h41;
  localparam logic [7:0] CMD_KEEP    = 8'h27;
  localparam int         CMD_MEM_BIT = 1;
  localparam logic [1:0] APSZ_BIG    = 2'd2;
  localparam logic [3:0] MAP_WIDE    = 4'h0;
  localparam logic [3:0] MAP_TEXT    = 4'hC;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] base;
    logic [1:0] apsz;
    logic [3:0] map;
  } cfg_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_VGA  = 2'd1,
    TGT_FB   = 2'd2,
    TGT_REG  = 2'd3
  } tgt_e;
endpackage

// File: rtl/gfx_cfg_regs.sv
module gfx_cfg_regs
  import gfx_aperture_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output cfg_t       cfg
);
  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      case (addr)
        CFG_CMD:     cfg_q.cmd  <= wdata & CMD_KEEP;
        CFG_BASE_HI: cfg_q.base <= wdata;
        CFG_APSZ:    cfg_q.apsz <= wdata[1:0];
        CFG_MAP:     cfg_q.map  <= wdata[3:0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      CFG_CMD:     rdata = cfg_q.cmd;
      CFG_BASE_HI: rdata = cfg_q.base;
      CFG_APSZ:    rdata = {6'd0, cfg_q.apsz};
      CFG_MAP:     rdata = {4'd0, cfg_q.map};
      default:     rdata = 8'h00;
    endcase
  end

  assign cfg = cfg_q;

  AST_CMD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CFG_CMD) |=> (cfg_q.cmd == ($past(wdata) & CMD_KEEP))); // R2
  AST_BASE_LO_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CFG_BASE_LO) |=> (cfg_q.base == $past(cfg_q.base))); // R4
endmodule

// File: rtl/gfx_legacy_decode.sv
module gfx_legacy_decode
  import gfx_aperture_pkg::*;
(
  input  logic [HOST_AW-1:0] addr,
  input  logic               mem_en,
  input  logic [3:0]         map,
  output logic               vga_hit,
  output logic               reg_hit,
  output logic [15:0]        vga_off
);
  localparam logic [HOST_AW-1:0] WIDE_LO = 32'h000A_0000;
  localparam logic [HOST_AW-1:0] TEXT_LO = 32'h000B_8000;
  localparam logic [HOST_AW-1:0] REG_LO  = 32'h000C_0000 - REG_WIN;
  localparam logic [HOST_AW-1:0] REG_HI  = 32'h000C_0000;

  logic in_wide, in_text, in_reg;

  always_comb begin
    in_wide = (addr >= WIDE_LO) && (addr < REG_LO);
    in_text = (addr >= TEXT_LO) && (addr < REG_LO);
    in_reg  = (addr >= REG_LO)  && (addr < REG_HI);
    vga_hit = 1'b0;
    reg_hit = 1'b0;
    vga_off = '0;
    if (mem_en) begin
      case (map)
        MAP_WIDE: begin
          vga_hit = in_wide;
          reg_hit = in_reg;
          vga_off = addr[15:0];
        end
        MAP_TEXT: begin
          vga_hit = in_text;
          vga_off = {1'b0, addr[14:0]};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gfx_linear_decode.sv
module gfx_linear_decode
  import gfx_aperture_pkg::*;
(
  input  logic [HOST_AW-1:0] addr,
  input  logic               mem_en,
  input  logic [7:0]         base,
  input  logic [1:0]         apsz,
  input  logic [APER_AW:0]   vram_bytes,
  output logic               fb_hit,
  output logic               reg_hit,
  output logic [APER_AW-1:0] fb_off
);
  localparam logic [APER_AW:0] SIZE_BIG   = 1 << APER_AW;
  localparam logic [APER_AW:0] SIZE_SMALL = 1 << (APER_AW - 1);

  logic [APER_AW:0] size, fb_lim, off;
  logic             in_win;

  always_comb begin
    size   = (apsz == APSZ_BIG) ? SIZE_BIG : SIZE_SMALL;
    fb_lim = size - REG_WIN[APER_AW:0];
    off    = addr[BASE_SHIFT-1:0];
    in_win = mem_en && (base != 8'd0) &&
             (addr[HOST_AW-1:BASE_SHIFT] == base) && (off < size);
    fb_hit  = in_win && (off < fb_lim) && (off < vram_bytes);
    reg_hit = in_win && (off >= fb_lim);
    fb_off  = off[APER_AW-1:0];
  end
endmodule

// File: rtl/gfx_aperture_decoder.sv
module gfx_aperture_decoder
  import gfx_aperture_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [APER_AW:0]   vram_bytes,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [DW-1:0]      vram_rdata,
  input  logic [DW-1:0]      reg_rdata,
  output logic               sel_vga,
  output logic               sel_fb,
  output logic               sel_reg,
  output logic [APER_AW-1:0] vram_off,
  output logic [REG_AW-1:0]  reg_off,
  output logic [DW-1:0]      host_rdata,
  output logic               host_drop
);
  cfg_t               cfg;
  logic               mem_en, access;
  logic               lg_vga, lg_reg, ln_fb, ln_reg;
  logic [15:0]        lg_off;
  logic [APER_AW-1:0] ln_off;
  tgt_e               tgt;

  gfx_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  assign mem_en = cfg.cmd[CMD_MEM_BIT];
  assign access = host_rd | host_wr;

  gfx_legacy_decode u_legacy (
    .addr(host_addr), .mem_en(mem_en), .map(cfg.map),
    .vga_hit(lg_vga), .reg_hit(lg_reg), .vga_off(lg_off)
  );

  gfx_linear_decode u_linear (
    .addr(host_addr), .mem_en(mem_en), .base(cfg.base), .apsz(cfg.apsz),
    .vram_bytes(vram_bytes), .fb_hit(ln_fb), .reg_hit(ln_reg), .fb_off(ln_off)
  );

  always_comb begin
    tgt      = TGT_NONE;
    vram_off = '0;
    if (access) begin
      if (lg_vga) begin
        tgt      = TGT_VGA;
        vram_off = {{(APER_AW-16){1'b0}}, lg_off};
      end else if (ln_fb) begin
        tgt      = TGT_FB;
        vram_off = ln_off;
      end else if (lg_reg || ln_reg) begin
        tgt = TGT_REG;
      end
    end
    sel_vga   = (tgt == TGT_VGA);
    sel_fb    = (tgt == TGT_FB);
    sel_reg   = (tgt == TGT_REG);
    reg_off   = sel_reg ? host_addr[REG_AW-1:0] : '0;
    host_drop = access && (tgt == TGT_NONE);
    case (tgt)
      TGT_VGA, TGT_FB: host_rdata = vram_rdata;
      TGT_REG:         host_rdata = reg_rdata;
      default:         host_rdata = '1;
    endcase
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_vga, sel_fb, sel_reg})); // R10
  AST_MEM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[CMD_MEM_BIT] && cfg_addr == CFG_CMD |-> !(sel_vga || sel_fb || sel_reg)); // R3
  AST_FB_IN_VRAM: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fb |-> ({1'b0, vram_off} < vram_bytes)); // R9
  AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_drop) |-> (host_rdata == '1)); // R10
endmodule

// File: tb/test_gfx_aperture_decoder.sv
module test_gfx_aperture_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VDATA = 32'hA5A5_1234;
  localparam logic [31:0] RDATA = 32'h3C3C_5678;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [23:0] vram_bytes = 24'h800000;
  logic [31:0] host_addr = 0;
  logic        host_rd = 0, host_wr = 0;
  logic        sel_vga, sel_fb, sel_reg, host_drop;
  logic [22:0] vram_off;
  logic [9:0]  reg_off;
  logic [31:0] host_rdata;

  int checks = 0, fails = 0;
  logic [7:0] m_cmd = 0, m_base = 0;
  logic [1:0] m_apsz = 0;
  logic [3:0] m_map = 0;

  gfx_aperture_decoder i_gfx_aperture_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vram_bytes(vram_bytes),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .vram_rdata(VDATA), .reg_rdata(RDATA), .sel_vga(sel_vga), .sel_fb(sel_fb),
    .sel_reg(sel_reg), .vram_off(vram_off), .reg_off(reg_off),
    .host_rdata(host_rdata), .host_drop(host_drop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      8'h04: m_cmd  = d & 8'h27;
      8'h13: m_base = d;
      8'h40: m_apsz = d[1:0];
      8'h41: m_map  = d[3:0];
      default: ;
    endcase
  endtask

  task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cfg_addr = a; #1;
    check(cfg_rdata == exp, tag, "cfg readback", {24'd0, cfg_rdata}, {24'd0, exp});
  endtask

  task automatic model(input logic [31:0] a, output int tgt,
                       output logic [22:0] vo, output logic [9:0] ro);
    longint base, sz, o;
    tgt = 0; vo = 0; ro = 0;
    if (m_cmd[1]) begin
      if (m_map == 4'h0) begin
        if (a >= 32'hA0000 && a < 32'hBFC00) begin tgt = 1; vo = {7'd0, a[15:0]}; end
        else if (a >= 32'hBFC00 && a < 32'hC0000) begin tgt = 3; ro = a[9:0]; end
      end else if (m_map == 4'hC && a >= 32'hB8000 && a < 32'hBFC00) begin
        tgt = 1; vo = {8'd0, a[14:0]};
      end
      if (m_base != 0) begin
        base = longint'(m_base) << 24;
        sz   = (m_apsz == 2) ? 64'h800000 : 64'h400000;
        if (longint'(a) >= base && longint'(a) < base + sz) begin
          o = longint'(a) - base;
          if (o < sz - 1024) begin
            if (o < longint'(vram_bytes)) begin tgt = 2; vo = o[22:0]; end
          end else begin
            tgt = 3; ro = o[9:0];
          end
        end
      end
    end
  endtask

  task automatic probe(input logic [31:0] a, input bit wr, input string tag);
    int tgt, act;
    logic [22:0] vo;
    logic [9:0] ro;
    logic [31:0] exp_d;
    host_addr = a; host_rd = !wr; host_wr = wr;
    #1;
    model(a, tgt, vo, ro);
    act = sel_vga ? 1 : sel_fb ? 2 : sel_reg ? 3 : 0;
    check(act == tgt && (sel_vga + sel_fb + sel_reg) <= 1, tag, "target", act, tgt);
    check(host_drop == (tgt == 0), tag, "drop", {31'd0, host_drop}, {31'd0, tgt == 0});
    if (tgt == 1 || tgt == 2)
      check(vram_off == vo, tag, "vram offset", {9'd0, vram_off}, {9'd0, vo});
    if (tgt == 3)
      check(reg_off == ro, tag, "reg offset", {22'd0, reg_off}, {22'd0, ro});
    if (!wr) begin
      exp_d = (tgt == 0) ? 32'hFFFF_FFFF : (tgt == 3) ? RDATA : VDATA;
      check(host_rdata == exp_d, tag, "read data", host_rdata, exp_d);
    end
    host_rd = 0; host_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  bases [3];
    logic [23:0] vrams [3];
    logic [31:0] lg_addrs [10];
    bases = '{8'h01, 8'h10, 8'hFF};
    vrams = '{24'h100000, 24'h400000, 24'h800000};
    lg_addrs = '{32'h9FFFF, 32'hA0000, 32'hAFFFF, 32'hB7FFF, 32'hB8000,
                 32'hBC123, 32'hBFBFF, 32'hBFC00, 32'hBFFFF, 32'hC0000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    cfg_check(8'h04, 8'h00, "R1");
    cfg_check(8'h13, 8'h00, "R1");
    cfg_check(8'h40, 8'h00, "R1");
    cfg_check(8'h41, 8'h00, "R1");
    probe(32'hA0000, 0, "R1");

    // R2: command mask
    cfg_write(8'h04, 8'hFF);
    cfg_check(8'h04, 8'h27, "R2");
    cfg_write(8'h40, 8'hFF);
    cfg_check(8'h40, 8'h03, "R1");
    cfg_write(8'h41, 8'hF0);
    cfg_check(8'h41, 8'h00, "R1");
    cfg_check(8'h77, 8'h00, "R1");

    // R4: base byte high, low byte inert
    cfg_write(8'h13, 8'h42);
    cfg_write(8'h12, 8'hAB);
    cfg_check(8'h12, 8'h00, "R4");
    cfg_check(8'h13, 8'h42, "R4");
    cfg_write(8'h13, 8'h00);
    probe(32'h0000_1000, 0, "R4");
    probe(32'h0000_0000, 1, "R4");

    // R5/R6/R9: linear aperture sweep
    for (int s = 0; s < 4; s++) begin
      cfg_write(8'h40, 8'(s));
      for (int b = 0; b < 3; b++) begin
        cfg_write(8'h13, bases[b]);
        for (int v = 0; v < 3; v++) begin
          longint base, sz;
          longint offs [10];
          vram_bytes = vrams[v];
          base = longint'(bases[b]) << 24;
          sz = (s == 2) ? 64'h800000 : 64'h400000;
          offs = '{-1, 0, 64'h3FF, longint'(vrams[v]) - 1, longint'(vrams[v]),
                   sz - 64'h401, sz - 64'h400, sz - 64'h3FF + 64'h1F0, sz - 1, sz};
          for (int k = 0; k < 10; k++) begin
            logic [31:0] a;
            a = 32'(base + offs[k]);
            probe(a, 0, (s == 2) ? "R5" : "R6");
            if (offs[k] >= longint'(vrams[v]) && offs[k] < sz - 1024)
              probe(a, 1, "R9");
          end
        end
      end
    end

    // R7/R8: legacy map sweep
    cfg_write(8'h13, 8'h00);
    for (int m = 0; m < 16; m++) begin
      cfg_write(8'h41, 8'(m));
      for (int k = 0; k < 10; k++)
        probe(lg_addrs[k], k[0], (m == 0) ? "R7" : "R8");
    end

    // R3: memory enable clear gates everything
    cfg_write(8'h41, 8'h0);
    cfg_write(8'h13, 8'h10);
    cfg_write(8'h40, 8'h2);
    cfg_write(8'h04, 8'h05);
    cfg_check(8'h04, 8'h05, "R2");
    probe(32'hA0000, 0, "R3");
    probe(32'hBFC00, 0, "R3");
    probe(32'h1000_0000, 0, "R3");
    probe(32'h107F_FC00, 1, "R3");

    // R10: config write and access in the same cycle
    cfg_write(8'h04, 8'h02);
    vram_bytes = 24'h800000;
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'h13; cfg_wdata = 8'h20;
    host_addr = 32'h1000_0040; host_rd = 1;
    #1;
    check(sel_fb && host_rdata == VDATA, "R10", "old base during write cycle",
          {31'd0, sel_fb}, 32'd1);
    @(negedge clk);
    cfg_we = 0; m_base = 8'h20;
    #1;
    check(!sel_fb && host_drop && host_rdata == 32'hFFFF_FFFF, "R10",
          "new base after write", host_rdata, 32'hFFFF_FFFF);
    host_rd = 0;
    probe(32'h2000_0040, 0, "R10");
    probe(32'h203F_FC00, 0, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule